// File: doc/BRIEF.md
# Descriptor-Chained Receive Queue Engine

This block is the receive-channel controller of a descriptor-based Ethernet DMA. Software builds a linked list of receive descriptors in a descriptor RAM and arms the channel by writing the address of the first one to the head register. For every frame that arrives on a byte-wide streaming input, the engine takes one descriptor and stores the payload through a buffer-RAM write port. It then writes back the byte count and the status, hands the descriptor back to software and follows the link to the next descriptor.

A descriptor is four 32-bit words at a 16-byte aligned byte address:

| Offset | Contents |
|--------|----------|
| 0 | link to the next descriptor (0 ends the list) |
| 4 | buffer byte address |
| 8 | buffer size in bits 15:0 (the engine rewrites it with the stored byte count) |
| 12 | flags and length |

The flag and length word uses these bits:

| Bit(s) | Meaning |
|--------|---------|
| 31 | start of frame |
| 30 | end of frame |
| 29 | owned by the engine |
| 28 | end of queue |
| 26 | error |
| 15:0 | length |

Software acknowledges each finished descriptor by writing its address to the completion register. An interrupt line stays high until that acknowledgement matches the last descriptor the engine finished. A teardown request stops the channel and reports completion with the marker 0xFFFFFFFC in the completion register.

Top module: `rxq_engine`

## Requirements
- R1: While the engine is idle, a head write with a nonzero address starts processing at that descriptor. A head write of zero leaves the engine idle, so `rx_active` and `s_ready` stay low. Head writes made while the engine is active are ignored.
- R2: The engine only processes a descriptor whose engine-owned bit (bit 29 of the word at offset 12) is set. If that bit is clear at the descriptor it fetches, the engine returns to idle, leaves the descriptor unchanged and accepts no stream data.
- R3: When a frame ends, the engine writes the stored byte count to bits 15:0 of both the offset-8 word and the offset-12 word. In the offset-12 word it clears bit 29 and sets bits 31 and 30.
- R4: Payload byte i of a frame is written to buffer address (buffer pointer + i), in arrival order.
- R5: If the completed descriptor's link is zero, the engine sets bit 28 in it and goes idle. Otherwise it leaves bit 28 clear and continues with the linked descriptor. A new head write restarts an idle engine.
- R6: If `s_err` is high on any beat of a frame, bit 26 is set in that descriptor's offset-12 word.
- R7: The byte limit of a frame is the smaller of the descriptor's buffer size and `max_len`. Bytes beyond the limit are accepted and dropped, the length reports the limit, and bit 26 is set. A frame of exactly the limit is not flagged.
- R8: `irq` is high while `cp_out` differs from the address of the last descriptor the engine completed. A write to the completion register sets `cp_out` to the written value.
- R9: A teardown request takes effect while the engine is idle, or while it waits for the first byte of a frame. The engine then sets `cp_out` to 0xFFFFFFFC, goes idle with `irq` low and leaves the pending descriptor still owned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdp_wr | input | 1 | Head register write strobe |
| hdp_data | input | 32 | Head descriptor byte address |
| cp_wr | input | 1 | Completion register write strobe |
| cp_data | input | 32 | Completion register write value |
| tdown_wr | input | 1 | Teardown request strobe |
| max_len | input | 16 | Programmable maximum receive length |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Last byte of frame |
| s_err | input | 1 | Frame error flag for this beat |
| s_ready | output | 1 | Stream byte accepted |
| dm_addr | output | 32 | Descriptor RAM byte address |
| dm_we | output | 1 | Descriptor RAM write enable |
| dm_wdata | output | 32 | Descriptor RAM write data |
| dm_rdata | input | 32 | Descriptor RAM read data, one cycle after address |
| bw_en | output | 1 | Buffer RAM byte write enable |
| bw_addr | output | 32 | Buffer RAM byte address |
| bw_data | output | 8 | Buffer RAM byte data |
| cp_out | output | 32 | Completion register value |
| irq | output | 1 | Completion interrupt pending |
| rx_active | output | 1 | Engine is walking the descriptor list |

## Verification
The assertions take for granted that the descriptor RAM is a synchronous memory whose read data follows the address by one cycle. They also assume that descriptors are 16-byte aligned, so the offset-12 write is recognised by its low address bits, and that software never writes the completion register in the cycle a teardown fires. The bench keeps to these conditions: it places every descriptor on a 16-byte boundary and models the RAM with a one-cycle read. It issues completion writes only when no teardown is pending, and it drives stream beats at the falling edge, holding them until `s_ready` is high.

// File: rtl/rxq_pkg.sv
// Shared constants and types of the receive queue engine.
// Assumes descriptors are four 32-bit words on a 16-byte boundary.
package rxq_pkg;
    localparam int PTR_W = 32;
    localparam int LEN_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [PTR_W-1:0] OFS_NEXT = 32'd0;
    localparam logic [PTR_W-1:0] OFS_BUF  = 32'd4;
    localparam logic [PTR_W-1:0] OFS_LEN  = 32'd8;
    localparam logic [PTR_W-1:0] OFS_FLAG = 32'd12;

    localparam int FL_SOP = 31;
    localparam int FL_EOP = 30;
    localparam int FL_OWN = 29;
    localparam int FL_EOQ = 28;
    localparam int FL_ERR = 26;

    localparam logic [PTR_W-1:0] TDOWN_MARK = 32'hFFFF_FFFC;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_FLAG, ST_RD_BUF, ST_RD_LEN, ST_RD_NEXT,
        ST_LOAD, ST_RECV, ST_WR_LEN, ST_WR_FLAG
    } rxq_st_t;
endpackage

// File: rtl/rxq_fill.sv
// Frame fill unit: accepts stream bytes, writes them into the buffer up
// to a byte limit, and tracks the count and the error/truncation state.
// Assumes load is pulsed once before each frame.
module rxq_fill
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PTR_W-1:0]  base,
    input  logic [LEN_W-1:0]  limit,
    input  logic              en,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_err,
    output logic              s_ready,
    output logic              bw_en,
    output logic [PTR_W-1:0]  bw_addr,
    output logic [BYTE_W-1:0] bw_data,
    output logic [LEN_W-1:0]  count,
    output logic              bad,
    output logic              started,
    output logic              done
);
    localparam int PAD_W = PTR_W - LEN_W;

    logic [LEN_W-1:0] cnt_q, lim_q;
    logic [PTR_W-1:0] base_q;
    logic             bad_q, started_q;
    logic             beat, room;

    // Stream handshake and buffer write decode.
    always_comb begin
        beat    = en && s_valid;
        room    = cnt_q < lim_q;
        s_ready = en;
        bw_en   = beat && room;
        bw_addr = base_q + {{PAD_W{1'b0}}, cnt_q};
        bw_data = s_data;
        done    = beat && s_last;
        count   = cnt_q;
        bad     = bad_q;
        started = started_q;
    end

    // Per-frame count, limit and error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            base_q    <= '0;
            bad_q     <= 1'b0;
            started_q <= 1'b0;
        end else if (load) begin
            cnt_q     <= '0;
            lim_q     <= limit;
            base_q    <= base;
            bad_q     <= 1'b0;
            started_q <= 1'b0;
        end else if (beat) begin
            started_q <= 1'b1;
            if (room) cnt_q <= cnt_q + 1'b1;
            bad_q <= bad_q || s_err || !room;
        end
    end
endmodule

// File: rtl/rxq_cpreg.sv
// Completion pointer register and interrupt-pending logic.
// Assumes software and teardown never write in the same cycle.
module rxq_cpreg
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cp_wr,
    input  logic [PTR_W-1:0] cp_data,
    input  logic             done_evt,
    input  logic [PTR_W-1:0] done_addr,
    input  logic             tdown_evt,
    output logic [PTR_W-1:0] cp_out,
    output logic             irq
);
    logic [PTR_W-1:0] cp_q, last_q;

    // Completion value and last-completed descriptor tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_q   <= '0;
            last_q <= '0;
        end else if (tdown_evt) begin
            cp_q   <= TDOWN_MARK;
            last_q <= TDOWN_MARK;
        end else begin
            if (cp_wr) cp_q <= cp_data;
            if (done_evt) last_q <= done_addr;
        end
    end

    // Pending while software has not acknowledged the latest completion.
    always_comb begin
        cp_out = cp_q;
        irq    = cp_q != last_q;
    end
endmodule

// File: rtl/rxq_ctrl.sv
// Descriptor walk sequencer: fetches a descriptor, checks ownership,
// runs the fill unit for one frame, writes back count and status and
// follows the link. Handles teardown at frame boundaries.
// Assumes a descriptor RAM with one-cycle read latency.
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdp_wr,
    input  logic [PTR_W-1:0] hdp_data,
    input  logic             tdown_wr,
    input  logic [LEN_W-1:0] max_len,
    output logic [PTR_W-1:0] dm_addr,
    output logic             dm_we,
    output logic [PTR_W-1:0] dm_wdata,
    input  logic [PTR_W-1:0] dm_rdata,
    output logic             fill_load,
    output logic [PTR_W-1:0] fill_base,
    output logic [LEN_W-1:0] fill_limit,
    output logic             fill_en,
    input  logic             fill_started,
    input  logic             fill_done,
    input  logic [LEN_W-1:0] fill_count,
    input  logic             fill_bad,
    output logic             done_evt,
    output logic [PTR_W-1:0] done_addr,
    output logic             tdown_evt,
    output logic             rx_active
);
    localparam int PAD_W = PTR_W - LEN_W;

    rxq_st_t          st_q;
    logic [PTR_W-1:0] cur_q, buf_q, next_q;
    logic [LEN_W-1:0] blen_q;
    logic             tpend_q, tdown_go;
    logic [PTR_W-1:0] flag_word;

    // Teardown fires only where no frame is in flight.
    assign tdown_go = tpend_q &&
        ((st_q == ST_IDLE) || ((st_q == ST_RECV) && !fill_started));

    // Status word written back into a finished descriptor.
    always_comb begin
        flag_word             = '0;
        flag_word[FL_SOP]     = 1'b1;
        flag_word[FL_EOP]     = 1'b1;
        flag_word[FL_EOQ]     = (next_q == '0);
        flag_word[FL_ERR]     = fill_bad;
        flag_word[LEN_W-1:0]  = fill_count;
    end

    // Descriptor RAM port and fill unit controls.
    always_comb begin
        dm_we    = 1'b0;
        dm_wdata = '0;
        dm_addr  = cur_q;
        case (st_q)
            ST_RD_FLAG: dm_addr = cur_q + OFS_FLAG;
            ST_RD_BUF:  dm_addr = cur_q + OFS_BUF;
            ST_RD_LEN:  dm_addr = cur_q + OFS_LEN;
            ST_RD_NEXT: dm_addr = cur_q + OFS_NEXT;
            ST_WR_LEN: begin
                dm_addr  = cur_q + OFS_LEN;
                dm_we    = 1'b1;
                dm_wdata = {{PAD_W{1'b0}}, fill_count};
            end
            ST_WR_FLAG: begin
                dm_addr  = cur_q + OFS_FLAG;
                dm_we    = 1'b1;
                dm_wdata = flag_word;
            end
            default: ;
        endcase
        fill_load  = (st_q == ST_LOAD);
        fill_base  = buf_q;
        fill_limit = (blen_q < max_len) ? blen_q : max_len;
        fill_en    = (st_q == ST_RECV) && !tdown_go;
        done_evt   = (st_q == ST_WR_FLAG);
        done_addr  = cur_q;
        tdown_evt  = tdown_go;
        rx_active  = (st_q != ST_IDLE);
    end

    // Sequencer state, captured descriptor fields and teardown request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cur_q   <= '0;
            buf_q   <= '0;
            next_q  <= '0;
            blen_q  <= '0;
            tpend_q <= 1'b0;
        end else begin
            if (tdown_go)      tpend_q <= 1'b0;
            else if (tdown_wr) tpend_q <= 1'b1;
            case (st_q)
                ST_IDLE: begin
                    if (!tdown_go && hdp_wr && (hdp_data != '0)) begin
                        cur_q <= hdp_data;
                        st_q  <= ST_RD_FLAG;
                    end
                end
                ST_RD_FLAG: st_q <= ST_RD_BUF;
                ST_RD_BUF:  st_q <= dm_rdata[FL_OWN] ? ST_RD_LEN : ST_IDLE;
                ST_RD_LEN: begin
                    buf_q <= dm_rdata;
                    st_q  <= ST_RD_NEXT;
                end
                ST_RD_NEXT: begin
                    blen_q <= dm_rdata[LEN_W-1:0];
                    st_q   <= ST_LOAD;
                end
                ST_LOAD: begin
                    next_q <= dm_rdata;
                    st_q   <= ST_RECV;
                end
                ST_RECV: begin
                    if (tdown_go)       st_q <= ST_IDLE;
                    else if (fill_done) st_q <= ST_WR_LEN;
                end
                ST_WR_LEN: st_q <= ST_WR_FLAG;
                ST_WR_FLAG: begin
                    if (next_q == '0) begin
                        st_q <= ST_IDLE;
                    end else begin
                        cur_q <= next_q;
                        st_q  <= ST_RD_FLAG;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxq_engine.sv
// Top of the descriptor-chained receive queue engine: joins the walk
// sequencer, the fill unit and the completion register.
// Assumes 16-byte aligned descriptors in a one-cycle-latency RAM.
module rxq_engine
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hdp_wr,
    input  logic [31:0] hdp_data,
    input  logic        cp_wr,
    input  logic [31:0] cp_data,
    input  logic        tdown_wr,
    input  logic [15:0] max_len,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    input  logic        s_err,
    output logic        s_ready,
    output logic [31:0] dm_addr,
    output logic        dm_we,
    output logic [31:0] dm_wdata,
    input  logic [31:0] dm_rdata,
    output logic        bw_en,
    output logic [31:0] bw_addr,
    output logic [7:0]  bw_data,
    output logic [31:0] cp_out,
    output logic        irq,
    output logic        rx_active
);
    logic             fill_load, fill_en, fill_started, fill_done, fill_bad;
    logic [PTR_W-1:0] fill_base;
    logic [LEN_W-1:0] fill_limit, fill_count;
    logic             done_evt, tdown_evt;
    logic [PTR_W-1:0] done_addr;

    rxq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .hdp_wr(hdp_wr), .hdp_data(hdp_data),
        .tdown_wr(tdown_wr), .max_len(max_len),
        .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata),
        .fill_load(fill_load), .fill_base(fill_base),
        .fill_limit(fill_limit), .fill_en(fill_en),
        .fill_started(fill_started), .fill_done(fill_done),
        .fill_count(fill_count), .fill_bad(fill_bad),
        .done_evt(done_evt), .done_addr(done_addr),
        .tdown_evt(tdown_evt), .rx_active(rx_active)
    );

    rxq_fill u_fill (
        .clk(clk), .rst_n(rst_n),
        .load(fill_load), .base(fill_base), .limit(fill_limit),
        .en(fill_en),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_err(s_err), .s_ready(s_ready),
        .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
        .count(fill_count), .bad(fill_bad),
        .started(fill_started), .done(fill_done)
    );

    rxq_cpreg u_cp (
        .clk(clk), .rst_n(rst_n),
        .cp_wr(cp_wr), .cp_data(cp_data),
        .done_evt(done_evt), .done_addr(done_addr),
        .tdown_evt(tdown_evt),
        .cp_out(cp_out), .irq(irq)
    );
endmodule

// File: rtl/rxq_engine_chk.sv
// Protocol checker for rxq_engine, attached through bind.
// Assumes 16-byte aligned descriptors.
module rxq_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cp_wr,
    input logic        s_valid,
    input logic        s_ready,
    input logic [31:0] dm_addr,
    input logic        dm_we,
    input logic [31:0] dm_wdata,
    input logic        bw_en,
    input logic [31:0] cp_out,
    input logic        rx_active
);
    // R1: no stream data is taken while the engine is idle
    a_r1_idle_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |-> !s_ready);

    // R4: buffer writes happen only on an accepted beat
    a_r4_write_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        bw_en |-> (s_valid && s_ready));

    // R3: status write-back releases ownership and marks a whole frame
    a_r3_status_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_we && (dm_addr[3:0] == 4'hC)) |->
            (!dm_wdata[29] && dm_wdata[31] && dm_wdata[30]));

    // R5: an end-of-queue write-back is followed by an idle engine
    a_r5_eoq_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_we && (dm_addr[3:0] == 4'hC) && dm_wdata[28]) |=> !rx_active);

    // R9: the completion value changes on its own only to the teardown marker
    a_r9_self_marker: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cp_wr) && !$stable(cp_out)) |-> (cp_out == 32'hFFFF_FFFC));
endmodule

bind rxq_engine rxq_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cp_wr(cp_wr),
    .s_valid(s_valid), .s_ready(s_ready),
    .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata),
    .bw_en(bw_en), .cp_out(cp_out), .rx_active(rx_active)
);

// File: tb/rxq_engine_test.sv
// Directed bench for rxq_engine with descriptor and buffer RAM models.
module rxq_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdp_wr = 1'b0, cp_wr = 1'b0, tdown_wr = 1'b0;
    logic [31:0] hdp_data = '0, cp_data = '0;
    logic [15:0] max_len = 16'd1518;
    logic        s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready, dm_we, bw_en, irq, rx_active;
    logic [31:0] dm_addr, dm_wdata, bw_addr, cp_out;
    logic [31:0] dm_rdata = '0;
    logic [7:0]  bw_data;

    logic [31:0] dmem [0:255];
    logic [7:0]  bmem [0:1023];
    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    rxq_engine uut (
        .clk(clk), .rst_n(rst_n),
        .hdp_wr(hdp_wr), .hdp_data(hdp_data),
        .cp_wr(cp_wr), .cp_data(cp_data),
        .tdown_wr(tdown_wr), .max_len(max_len),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_err(s_err), .s_ready(s_ready),
        .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata),
        .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
        .cp_out(cp_out), .irq(irq), .rx_active(rx_active)
    );

    always @(posedge clk) begin
        if (dm_we) dmem[dm_addr[9:2]] <= dm_wdata;
        dm_rdata <= dmem[dm_addr[9:2]];
        if (bw_en) bmem[bw_addr[9:0]] <= bw_data;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dw(input int addr, input int ofs);
        return dmem[(addr + ofs) >> 2];
    endfunction

    task automatic put_desc(input int addr, input int nxt, input int bptr,
                            input int blen, input bit own);
        dmem[addr >> 2]       = nxt;
        dmem[(addr >> 2) + 1] = bptr;
        dmem[(addr >> 2) + 2] = blen;
        dmem[(addr >> 2) + 3] = own ? 32'h2000_0000 : 32'h0;
    endtask

    task automatic wr_hdp(input logic [31:0] v);
        @(negedge clk); hdp_wr = 1'b1; hdp_data = v;
        @(negedge clk); hdp_wr = 1'b0;
    endtask

    task automatic wr_cp(input logic [31:0] v);
        @(negedge clk); cp_wr = 1'b1; cp_data = v;
        @(negedge clk); cp_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input logic [7:0] first, input int err_idx);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = first + 8'(i);
            s_last = (i == n - 1); s_err = (i == err_idx);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
    endtask

    task automatic wait_done(input int addr);
        for (int k = 0; k < 400; k++) begin
            if (!dw(addr, 12)[29]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 reset rx_active", {31'd0, rx_active}, 32'd0);
        chk("R1 reset s_ready", {31'd0, s_ready}, 32'd0);
        chk("R8 reset irq", {31'd0, irq}, 32'd0);
        chk("R8 reset cp_out", cp_out, 32'd0);
    endtask

    task automatic t_single;
        logic ok;
        put_desc(32'h40, 0, 32'h100, 64, 1'b1);
        wr_hdp(32'h40);
        send_frame(20, 8'h10, -1);
        wait_done(32'h40);
        chk("R3 flag length", {16'd0, dw(32'h40, 12)[15:0]}, 32'd20);
        chk("R3 count word", dw(32'h40, 8), 32'd20);
        chk("R3 own/sop/eop", {29'd0, dw(32'h40, 12)[31:29]}, 32'd6);
        chk("R5 eoq on last", {31'd0, dw(32'h40, 12)[28]}, 32'd1);
        chk("R6 clean frame no error", {31'd0, dw(32'h40, 12)[26]}, 32'd0);
        ok = 1'b1;
        for (int i = 0; i < 20; i++) if (bmem[32'h100 + i] !== 8'(8'h10 + i)) ok = 1'b0;
        chk("R4 payload order", {31'd0, ok}, 32'd1);
        idle(2);
        chk("R5 idle after eoq", {31'd0, rx_active}, 32'd0);
        chk("R8 irq pending", {31'd0, irq}, 32'd1);
        wr_cp(32'h40);
        chk("R8 cp_out written", cp_out, 32'h40);
        chk("R8 irq cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_chain;
        put_desc(32'h80, 32'hC0, 32'h200, 64, 1'b1);
        put_desc(32'hC0, 0, 32'h280, 64, 1'b1);
        wr_hdp(32'h80);
        send_frame(5, 8'h30, -1);
        wait_done(32'h80);
        chk("R5 no eoq mid-list", {31'd0, dw(32'h80, 12)[28]}, 32'd0);
        chk("R3 first length", {16'd0, dw(32'h80, 12)[15:0]}, 32'd5);
        chk("R5 continues", {31'd0, rx_active}, 32'd1);
        send_frame(9, 8'h40, -1);
        wait_done(32'hC0);
        chk("R5 eoq at end", {31'd0, dw(32'hC0, 12)[28]}, 32'd1);
        chk("R3 second length", {16'd0, dw(32'hC0, 12)[15:0]}, 32'd9);
        chk("R4 second buffer", {24'd0, bmem[32'h288]}, 32'h48);
        idle(2);
        chk("R8 irq after chain", {31'd0, irq}, 32'd1);
        wr_cp(32'hC0);
        chk("R8 irq acked", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_error;
        put_desc(32'h100, 0, 32'h2C0, 64, 1'b1);
        wr_hdp(32'h100);
        send_frame(6, 8'h60, 3);
        wait_done(32'h100);
        chk("R6 error flag", {31'd0, dw(32'h100, 12)[26]}, 32'd1);
        chk("R6 error length kept", {16'd0, dw(32'h100, 12)[15:0]}, 32'd6);
        idle(2);
        wr_cp(32'h100);
    endtask

    task automatic t_trunc;
        bmem[32'h308] = 8'hEE;
        put_desc(32'h140, 0, 32'h300, 8, 1'b1);
        wr_hdp(32'h140);
        send_frame(12, 8'h50, -1);
        wait_done(32'h140);
        chk("R7 truncated length", {16'd0, dw(32'h140, 12)[15:0]}, 32'd8);
        chk("R7 truncated count word", dw(32'h140, 8), 32'd8);
        chk("R7 truncation error", {31'd0, dw(32'h140, 12)[26]}, 32'd1);
        chk("R7 last kept byte", {24'd0, bmem[32'h307]}, 32'h57);
        chk("R7 excess dropped", {24'd0, bmem[32'h308]}, 32'hEE);
        idle(2);
        wr_cp(32'h140);
        // exact fit is not flagged
        put_desc(32'h1C0, 0, 32'h3C0, 4, 1'b1);
        wr_hdp(32'h1C0);
        send_frame(4, 8'h01, -1);
        wait_done(32'h1C0);
        chk("R7 exact fit no error", {31'd0, dw(32'h1C0, 12)[26]}, 32'd0);
        idle(2);
        wr_cp(32'h1C0);
    endtask

    task automatic t_maxlen;
        max_len = 16'd5;
        put_desc(32'h180, 0, 32'h340, 64, 1'b1);
        wr_hdp(32'h180);
        send_frame(7, 8'h70, -1);
        wait_done(32'h180);
        chk("R7 max_len limit", {16'd0, dw(32'h180, 12)[15:0]}, 32'd5);
        chk("R7 max_len error", {31'd0, dw(32'h180, 12)[26]}, 32'd1);
        max_len = 16'd1518;
        idle(2);
        wr_cp(32'h180);
    endtask

    task automatic t_not_owned;
        put_desc(32'h1C0, 0, 32'h3C0, 64, 1'b0);
        dmem[(32'h1C0 >> 2) + 3] = 32'h0000_1234;
        wr_hdp(32'h1C0);
        idle(10);
        chk("R2 idle on unowned", {31'd0, rx_active}, 32'd0);
        chk("R2 no ready on unowned", {31'd0, s_ready}, 32'd0);
        chk("R2 descriptor untouched", dw(32'h1C0, 12), 32'h0000_1234);
    endtask

    task automatic t_zero_head;
        wr_hdp(32'h0);
        idle(3);
        chk("R1 zero head stays idle", {30'd0, rx_active, s_ready}, 32'd0);
    endtask

    task automatic t_ignore_head;
        put_desc(32'h200, 0, 32'h380, 64, 1'b1);
        put_desc(32'h240, 0, 32'h3A0, 64, 1'b1);
        wr_hdp(32'h200);
        idle(10);
        wr_hdp(32'h240);
        send_frame(4, 8'h90, -1);
        wait_done(32'h200);
        chk("R1 first head used", {16'd0, dw(32'h200, 12)[15:0]}, 32'd4);
        idle(3);
        chk("R1 second head ignored", dw(32'h240, 12), 32'h2000_0000);
        chk("R1 idle after ignored head", {31'd0, rx_active}, 32'd0);
        wr_cp(32'h200);
    endtask

    task automatic t_teardown;
        put_desc(32'h280, 0, 32'h3E0, 64, 1'b1);
        wr_hdp(32'h280);
        idle(10);
        @(negedge clk); tdown_wr = 1'b1;
        @(negedge clk); tdown_wr = 1'b0;
        idle(3);
        chk("R9 teardown marker", cp_out, 32'hFFFF_FFFC);
        chk("R9 idle after teardown", {30'd0, rx_active, s_ready}, 32'd0);
        chk("R9 irq low", {31'd0, irq}, 32'd0);
        chk("R9 descriptor still owned", dw(32'h280, 12), 32'h2000_0000);
        // restart after teardown
        wr_hdp(32'h280);
        send_frame(3, 8'hA0, -1);
        wait_done(32'h280);
        chk("R5 restart by head write", {16'd0, dw(32'h280, 12)[15:0]}, 32'd3);
    endtask

    initial begin
        #(8 * 150000);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) dmem[i] = '0;
        for (int i = 0; i < 1024; i++) bmem[i] = '0;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_single();
        t_chain();
        t_error();
        t_trunc();
        t_maxlen();
        t_not_owned();
        t_zero_head();
        t_ignore_head();
        t_teardown();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule